// File: doc/BRIEF.md
# Burst SRAM Address and Write Control

This block is the synchronous front end of a burst SRAM with a parameterised internal array. An access begins when one of two active-low address strobes is sampled low. The processor strobe takes priority, counts only while the primary chip enable is active, and always opens a read. The controller strobe opens a read or a write, depending on the write controls. The chip-enable triple is captured only on a strobe cycle. After that the block runs on its own until the next strobe.

A 2-bit beat counter forms the low two address bits of each later beat. An active-low advance input steps the counter. With advance high and no strobe, the beat is suspended: the same address is used again, and a write may be placed on it. That is the only way to write into an access opened by the processor strobe. A live order input picks the beat order. Low gives a linear step of +1 modulo 4 from the start value. High gives an interleaved order, where the start value is XORed with the beat count. Either way the address returns to the start value after four beats.

Write controls are decoded into per-byte-lane enables. A global write writes every lane. A byte-write enable passes the individual active-low lane strobes through. With neither asserted, the beat is a read. Read data leaves through a flow-through stage or an extra pipeline register, chosen by a mode input. The output-enable gating is combinational.

Top module: `burst_sram_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, and until the first read after reset, `rvalid` is 0 and `rdata` is all zeros.
- R2: With `adsp_n` not taking effect, `adsc_n` low at an edge starts an access at `addr`. It is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 at that edge. The beat at that edge writes if any lane enable is decoded, and reads otherwise.
- R3: `adsp_n` low with `ce1_n` low starts an access at `addr` that is always a read, whatever the write inputs are. A write to that address takes place on the next edge if that beat is suspended with a write decoded.
- R4: `adsp_n` low while `ce1_n` is high is ignored. That edge behaves exactly as if `adsp_n` were high.
- R5: `ce1_n`, `ce2` and `ce3_n` are sampled only on strobe edges. An access started while not selected performs no reads or writes until the next strobe, and enable changes between strobes have no effect.
- R6: With `burst_order`=0, each edge with `adv_n` low and no strobe moves the low two address bits to (start + beat) mod 4, where beat is the count of advances since the strobe, modulo 4.
- R7: With `burst_order`=1, the low two address bits are start XOR beat. The upper address bits never change within an access.
- R8: After four advances the beat address is back at the start address.
- R9: An edge with `adv_n` high and no strobe reuses the current beat address. A selected access then reads or writes that address again.
- R10: Lane decode: `gw_n`=0 writes all lanes. Otherwise, `bwe_n`=0 writes lane i when `bw_n[i]`=0. Otherwise the beat is a read. Lane i is `wdata[8i+7:8i]`. A write beat produces no read result.
- R11: With `flow_thru`=1, the data of a read at edge E is presented after E. With `flow_thru`=0, it is presented after edge E+1.
- R12: `rvalid` is 1 only when the selected output stage holds a read result and `oe_n`=0. When `rvalid` is 0, `rdata` is zero. The response to `oe_n` is immediate, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Start address, captured on a strobe |
| adsp_n | input | 1 | Processor address strobe, active low, read-only start |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Beat advance, active low |
| ce1_n | input | 1 | Primary chip enable, active low, also gates `adsp_n` |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | BYTES | Per-lane write strobes, active low |
| burst_order | input | 1 | 0 linear, 1 interleaved |
| flow_thru | input | 1 | 1 flow-through, 0 pipelined output |
| oe_n | input | 1 | Output enable, active low, combinational |
| wdata | input | BYTES*BYTE_W | Write data |
| rdata | output | BYTES*BYTE_W | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The bench probes the edges where strobe priority matters. It drives the processor strobe with write controls asserted, and a design that let those controls through would overwrite memory at the start of that access. It also drives the processor strobe while the primary enable is off, and a design that did not gate it would restart the access at a stray address. Bursts run in both orders from a start value that is not aligned, and continue past four beats. This exposes an order mix-up, such as carrying into bit 2 or adding where an XOR belongs, or a failure to wrap. It also catches a counter that skips or repeats beats around a suspend. Lane-only writes, a change in mid-burst enables, and a switch of output mode show whether a design writes the wrong lanes, samples enables late, or puts data on the wrong cycle.

// File: rtl/burst_sram_pkg.sv
// Shared types for the burst SRAM front end.
package burst_sram_pkg;

    // Kind of array access performed on a clock edge.
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_t;

endpackage

// File: rtl/burst_addr_seq.sv
// Beat address sequencer.
// Holds the start address and a 2-bit beat count. On a start the beat count
// clears and the start address is taken from the input. An advance steps the
// count modulo 4. The effective address for the current edge is driven
// combinationally, so the array sees the address the edge will use.
// Assumes start and advance are never both high (the caller gates advance).
module burst_addr_seq #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              advance,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [1:0]        beat
);

    localparam int HI_W = ADDR_W - 2;

    logic [ADDR_W-1:0] base_q, base_now;
    logic [1:0]        cnt_q, cnt_now;
    logic [1:0]        low_bits;

    // Select the base and beat count that this edge uses.
    always_comb begin
        base_now = start ? start_addr : base_q;
        if (start) begin
            cnt_now = 2'd0;
        end else if (advance) begin
            cnt_now = cnt_q + 2'd1;
        end else begin
            cnt_now = cnt_q;
        end
    end

    // Form the low address bits in the selected order.
    always_comb begin
        if (interleave) begin
            low_bits = base_now[1:0] ^ cnt_now;
        end else begin
            low_bits = base_now[1:0] + cnt_now;
        end
        eff_addr = {base_now[ADDR_W-1:ADDR_W-HI_W], low_bits};
    end

    // Keep the access state between edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
        end else begin
            base_q <= base_now;
            cnt_q  <= cnt_now;
        end
    end

    assign beat = cnt_q;

endmodule

// File: rtl/burst_lane_decode.sv
// Write control decoder.
// Turns global write, byte-write enable and per-lane strobes (all active
// low) into one active-high request per byte lane. Purely combinational.
module burst_lane_decode #(
    parameter int BYTES = 2
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [BYTES-1:0] bw_n,
    output logic [BYTES-1:0] lane_req
);

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        // A lane writes on global write, or on byte enable with its strobe.
        assign lane_req[g] = !gw_n || (!bwe_n && !bw_n[g]);
    end

endmodule

// File: rtl/burst_read_stage.sv
// Read output staging.
// Stage 1 captures each read word at the edge of the read. Stage 2 delays it
// by one more edge. The mode input picks the stage that is presented. The
// output-enable gating and the zero-fill when not valid are combinational.
module burst_read_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_thru,
    input  logic              oe_n,
    input  logic              rd_fire,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              s1_valid,
    output logic              s2_valid
);

    logic [DATA_W-1:0] s1_data, s2_data;
    logic              pick_v;
    logic [DATA_W-1:0] pick_d;

    // Stage 1: hold the word read on this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_data  <= '0;
        end else begin
            s1_valid <= rd_fire;
            if (rd_fire) begin
                s1_data <= rd_word;
            end
        end
    end

    // Stage 2: one extra register for pipelined output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_data  <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_data  <= s1_data;
        end
    end

    // Select the presented stage and gate it with output enable.
    always_comb begin
        pick_v = flow_thru ? s1_valid : s2_valid;
        pick_d = flow_thru ? s1_data  : s2_data;
        rvalid = pick_v && !oe_n;
        rdata  = rvalid ? pick_d : '0;
    end

endmodule

// File: rtl/burst_sram_ctrl.sv
// Burst SRAM front end, top level.
// Arbitrates the two address strobes, captures the chip-enable state on a
// strobe, and drives the beat sequencer, the lane decoder, the array and the
// read stage. Assumes every input is synchronous to clk except oe_n, which
// only gates the output. The array is not reset.
module burst_sram_ctrl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    adsp_n,
    input  logic                    adsc_n,
    input  logic                    adv_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [BYTES-1:0]        bw_n,
    input  logic                    burst_order,
    input  logic                    flow_thru,
    input  logic                    oe_n,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    output logic [BYTES*BYTE_W-1:0] rdata,
    output logic                    rvalid
);

    localparam int DATA_W = BYTES * BYTE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              start_p, start_c, start_any;
    logic              sel_q, sel_now, advance;
    logic [ADDR_W-1:0] eff_addr;
    logic [1:0]        beat;
    logic [BYTES-1:0]  lane_req, lane_we;
    logic              s1_valid, s2_valid;
    cyc_kind_t         cyc_kind;
    logic [DATA_W-1:0] mem [DEPTH];

    // Strobe arbitration: the processor strobe wins, but only with ce1_n low.
    always_comb begin
        start_p   = !adsp_n && !ce1_n;
        start_c   = !adsc_n && !start_p;
        start_any = start_p || start_c;
        sel_now   = start_any ? (!ce1_n && ce2 && !ce3_n) : sel_q;
        advance   = !start_any && !adv_n;
    end

    // Keep the selection captured at the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else begin
            sel_q <= sel_now;
        end
    end

    burst_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_any),
        .advance    (advance),
        .interleave (burst_order),
        .start_addr (addr),
        .eff_addr   (eff_addr),
        .beat       (beat)
    );

    burst_lane_decode #(.BYTES(BYTES)) u_dec (
        .gw_n     (gw_n),
        .bwe_n    (bwe_n),
        .bw_n     (bw_n),
        .lane_req (lane_req)
    );

    // Classify the access on this edge; a processor start is always a read.
    always_comb begin
        if (!sel_now) begin
            cyc_kind = CYC_IDLE;
        end else if (!start_p && (|lane_req)) begin
            cyc_kind = CYC_WRITE;
        end else begin
            cyc_kind = CYC_READ;
        end
        lane_we = (cyc_kind == CYC_WRITE) ? lane_req : '0;
    end

    // Byte-lane writes into the array.
    always_ff @(posedge clk) begin
        for (int i = 0; i < BYTES; i++) begin
            if (lane_we[i]) begin
                mem[eff_addr][i*BYTE_W +: BYTE_W] <= wdata[i*BYTE_W +: BYTE_W];
            end
        end
    end

    burst_read_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .flow_thru (flow_thru),
        .oe_n      (oe_n),
        .rd_fire   (cyc_kind == CYC_READ),
        .rd_word   (mem[eff_addr]),
        .rdata     (rdata),
        .rvalid    (rvalid),
        .s1_valid  (s1_valid),
        .s2_valid  (s2_valid)
    );

endmodule

// File: rtl/burst_sram_ctrl_checks.sv
// Property checker for burst_sram_ctrl, attached by bind below.
// Observes ports and the hand-off signals between sub-blocks.
module burst_sram_ctrl_checks #(
    parameter int BYTES  = 2,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adsp_n,
    input logic              adsc_n,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              oe_n,
    input logic              flow_thru,
    input logic              rvalid,
    input logic [DATA_W-1:0] rdata,
    input logic [BYTES-1:0]  lane_we,
    input logic              advance,
    input logic [1:0]        beat,
    input logic              s1_valid,
    input logic              s2_valid
);

    // R12: output disabled means nothing is presented.
    assert_oe_gates_R12: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!rvalid && rdata == '0));

    // R3: a selected processor start yields a read result in flow mode.
    assert_adsp_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce1_n && ce2 && !ce3_n) |=> (oe_n || !flow_thru || rvalid));

    // R5: a controller start while deselected yields no read result.
    assert_desel_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n && !adsc_n && !ce2) |=> (!flow_thru || !rvalid));

    // R10: a write beat produces no read result.
    assert_write_no_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_we) |=> !s1_valid);

    // R11: the pipeline stage follows stage 1 by one edge.
    assert_pipe_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> s2_valid);

    // R8: the beat count wraps after the fourth step.
    assert_beat_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat == 2'd3 && advance) |=> (beat == 2'd0));

endmodule

bind burst_sram_ctrl burst_sram_ctrl_checks #(
    .BYTES  (BYTES),
    .DATA_W (BYTES*BYTE_W)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .adsp_n    (adsp_n),
    .adsc_n    (adsc_n),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .ce3_n     (ce3_n),
    .oe_n      (oe_n),
    .flow_thru (flow_thru),
    .rvalid    (rvalid),
    .rdata     (rdata),
    .lane_we   (lane_we),
    .advance   (advance),
    .beat      (beat),
    .s1_valid  (s1_valid),
    .s2_valid  (s2_valid)
);

// File: tb/burst_sram_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model, compared with the outputs every cycle.
module burst_sram_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic        ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic        gw_n = 1'b1, bwe_n = 1'b1;
    logic [1:0]  bw_n = 2'b11;
    logic        burst_order = 1'b0, flow_thru = 1'b1, oe_n = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rvalid;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string phase = "R1";

    // Reference model state.
    logic [15:0] mmem [256];
    int          m_base = 0, m_k = 0;
    bit          m_sel = 0;
    bit          m_s1v = 0, m_s2v = 0;
    logic [15:0] m_s1d = '0, m_s2d = '0;

    always #10 clk = ~clk;

    burst_sram_ctrl u_burst_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .burst_order(burst_order),
        .flow_thru(flow_thru), .oe_n(oe_n), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

    // Advance the model by one clock edge, using the inputs that edge saw.
    task automatic model_step();
        bit sp, sc, is_wr;
        int mask, ea, lo;
        if (!rst_n) begin
            m_sel = 0; m_k = 0; m_base = 0; m_s1v = 0; m_s2v = 0;
            return;
        end
        sp = (adsp_n == 0) && (ce1_n == 0);
        sc = !sp && (adsc_n == 0);
        if (sp || sc) begin
            m_base = addr;
            m_k = 0;
            m_sel = (ce1_n == 0) && (ce2 == 1) && (ce3_n == 0);
        end else if (adv_n == 0) begin
            m_k = (m_k + 1) % 4;
        end
        lo = burst_order ? ((m_base % 4) ^ m_k) : (((m_base % 4) + m_k) % 4);
        ea = (m_base / 4) * 4 + lo;
        mask = 0;
        for (int i = 0; i < 2; i++)
            if (gw_n == 0 || (bwe_n == 0 && bw_n[i] == 0)) mask = mask | (1 << i);
        is_wr = m_sel && !sp && (mask != 0);
        m_s2v = m_s1v;
        m_s2d = m_s1d;
        if (is_wr) begin
            for (int i = 0; i < 2; i++)
                if (mask[i]) mmem[ea][i*8 +: 8] = wdata[i*8 +: 8];
            m_s1v = 0;
        end else if (m_sel) begin
            m_s1v = 1;
            m_s1d = mmem[ea];
        end else begin
            m_s1v = 0;
        end
    endtask

    // Compare the outputs with the model, away from the clock edge.
    task automatic compare();
        bit          ev;
        logic [15:0] ed;
        ev = (flow_thru ? m_s1v : m_s2v) && (oe_n == 0);
        ed = ev ? (flow_thru ? m_s1d : m_s2d) : 16'h0000;
        total++;
        if (rvalid !== ev || rdata !== ed) begin
            bad++;
            $display("FAIL %s t=%0t rvalid=%b rdata=%h expected rvalid=%b rdata=%h",
                     phase, $time, rvalid, rdata, ev, ed);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle_inputs();
        adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 2'b11;
    endtask

    // Drive one cycle: strobes, advance, address, write controls, data.
    task automatic cyc(input logic sp_n, input logic sc_n, input logic av_n,
                       input logic [7:0] a, input logic g_n, input logic be_n,
                       input logic [1:0] b_n, input logic [15:0] d);
        adsp_n = sp_n; adsc_n = sc_n; adv_n = av_n; addr = a;
        gw_n = g_n; bwe_n = be_n; bw_n = b_n; wdata = d;
        tick();
    endtask

    // Controller-strobe read start followed by n advances.
    task automatic burst_read(input logic [7:0] a, input int n);
        cyc(1, 0, 1, a, 1, 1, 2'b11, 16'h0);
        for (int i = 0; i < n; i++) cyc(1, 1, 0, 8'h00, 1, 1, 2'b11, 16'h0);
        idle_inputs();
    endtask

    initial begin
        // R1: reset holds the outputs quiet.
        phase = "R1";
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1;
        tick();

        // R2: controller-strobe writes fill the array.
        phase = "R2";
        for (int a = 0; a < 256; a++)
            cyc(1, 0, 1, 8'(a), 0, 1, 2'b11, {8'(a) ^ 8'h5A, 8'(a)});
        idle_inputs();
        cyc(1, 0, 1, 8'h40, 1, 1, 2'b11, 16'h0);
        tick(); tick();

        // R6 and R8: linear order from an unaligned start, past four beats.
        phase = "R6_R8";
        burst_order = 0;
        burst_read(8'h11, 5);
        tick();

        // R7: interleaved order from start 2 and start 3.
        phase = "R7";
        burst_order = 1;
        burst_read(8'h22, 4);
        burst_read(8'h37, 3);
        tick();

        // R9: suspended beats reuse the address, then the burst continues.
        phase = "R9";
        burst_order = 0;
        cyc(1, 0, 1, 8'h52, 1, 1, 2'b11, 16'h0);
        cyc(1, 1, 0, 8'h00, 1, 1, 2'b11, 16'h0);
        cyc(1, 1, 1, 8'h00, 1, 1, 2'b11, 16'h0);
        cyc(1, 1, 1, 8'h00, 1, 1, 2'b11, 16'h0);
        cyc(1, 1, 0, 8'h00, 1, 1, 2'b11, 16'h0);
        tick();

        // R3: processor start with write asserted reads, next edge writes.
        phase = "R3";
        cyc(0, 1, 1, 8'h63, 0, 1, 2'b11, 16'h1111);
        cyc(1, 1, 1, 8'h00, 0, 1, 2'b11, 16'hBEEF);
        idle_inputs();
        burst_read(8'h63, 0);
        tick();

        // R4: processor strobe with ce1_n high is ignored mid-burst.
        phase = "R4";
        cyc(1, 0, 1, 8'h70, 1, 1, 2'b11, 16'h0);
        ce1_n = 1;
        cyc(0, 1, 0, 8'hF0, 1, 1, 2'b11, 16'h0);
        cyc(0, 1, 1, 8'hF1, 1, 1, 2'b11, 16'h0);
        ce1_n = 0;
        idle_inputs();
        tick();

        // R5: deselected start does nothing; mid-burst enable changes ignored.
        phase = "R5";
        ce2 = 0;
        cyc(1, 0, 1, 8'h80, 0, 1, 2'b11, 16'hDEAD);
        cyc(1, 1, 0, 8'h00, 0, 1, 2'b11, 16'hDEAD);
        ce2 = 1;
        cyc(1, 1, 0, 8'h00, 1, 1, 2'b11, 16'h0);
        burst_read(8'h80, 1);
        ce3_n = 1;
        cyc(1, 1, 0, 8'h00, 1, 1, 2'b11, 16'h0);
        ce3_n = 0;
        idle_inputs();
        tick();

        // R10: lane decode variants, then read back.
        phase = "R10";
        cyc(1, 0, 1, 8'h90, 1, 0, 2'b10, 16'hA1B2);
        cyc(1, 0, 1, 8'h91, 1, 0, 2'b01, 16'hC3D4);
        cyc(1, 0, 1, 8'h92, 1, 0, 2'b00, 16'hE5F6);
        cyc(1, 0, 1, 8'h93, 1, 1, 2'b00, 16'h0707);
        cyc(1, 0, 1, 8'h94, 0, 1, 2'b11, 16'h1234);
        idle_inputs();
        burst_read(8'h90, 4);
        tick();

        // R11: pipelined output delays each read by one more cycle.
        phase = "R11";
        flow_thru = 0;
        tick();
        burst_read(8'h15, 3);
        tick(); tick();
        flow_thru = 1;
        tick();

        // R12: output enable gates data immediately.
        phase = "R12";
        cyc(1, 0, 1, 8'hA0, 1, 1, 2'b11, 16'h0);
        oe_n = 1;
        cyc(1, 1, 0, 8'h00, 1, 1, 2'b11, 16'h0);
        #3;
        oe_n = 0;
        #1;
        compare();
        oe_n = 1;
        #1;
        compare();
        oe_n = 0;
        cyc(1, 1, 0, 8'h00, 1, 1, 2'b11, 16'h0);
        idle_inputs();
        tick();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 50000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired in phase %s", phase);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule